// File: doc/BRIEF.md
# Serial Bus Transfer Frame Engine

This block runs one serial bus transfer at a time. A caller writes an outgoing frame word while the engine is idle. The engine then waits until a programmable gap, counted in bit ticks since the previous frame ended, has passed. It then pulls an active-low frame line low and shifts the word out on a data line, most significant bit first. On the same bit ticks it samples the return line, so the incoming word is assembled while the outgoing one leaves. The frame word carries the data bits and any check bits together. The check arithmetic is done outside the block.

When the frame is over, the engine waits for an external check unit to report that its verdict is settled and whether the received word failed. It then stores the received word, together with that one-bit error verdict, in a small first-word-fall-through receive queue, and the not-empty flag rises. A reader pops the word and its error bit together. A word that arrives while the queue is full is discarded, and a sticky overflow flag records the loss.

Top module: `sbus_frame_engine`

## Requirements
- R1: After reset, frame_n is 1, sdo is 0, and busy, rx_not_empty and overflow are all 0.
- R2: A start pulse while busy is 0 latches tx_word, and busy reads 1 from the next cycle. A start pulse while busy is 1 is ignored, and the frame then sent is still the first latched word.
- R3: At the bit tick that ends a frame, the gap counter loads gap_ticks. The next frame_n fall happens on a bit tick. That tick is the gap_ticks+1-th tick counted from the end tick, or the first tick after a later start. After reset the first pending frame starts on its first tick.
- R4: On sdo, bit k of the frame word (k=0 being bit FRAME_W-1, the MSB) is driven from the k-th tick after the launch tick until the next tick. sdo is 0 while no frame is in progress.
- R5: sdi is sampled on ticks 1 to FRAME_W after the launch tick. The first sample becomes the MSB of the received word.
- R6: frame_n stays low through ticks 1 to FRAME_W-1 after the launch tick, and returns high on tick FRAME_W, one tick after the last bit was driven.
- R7: After a frame ends, nothing is queued and rx_not_empty does not change until crc_done is pulsed. The crc_done cycle stores the received word with crc_err. rx_not_empty then reads 1 and busy reads 0 from the next cycle.
- R8: rd_word and rd_err show the oldest queued entry. rd_en pops it. Order is first in, first out. rx_not_empty reads 0 the cycle after the last entry is popped.
- R9: The queue holds 4 entries. A store into a full queue is dropped, overflow becomes 1 and stays 1 until reset, and the queued entries are unchanged.
- R10: rd_en while the queue is empty has no effect. Later entries are still stored and read back correctly.
- R11: crc_done while no frame is awaiting its verdict is ignored: nothing is queued and busy stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_tick | input | 1 | One-cycle pulse marking a serial bit time |
| start | input | 1 | Request a transfer of tx_word |
| tx_word | input | FRAME_W | Outgoing frame word (data and check bits) |
| gap_ticks | input | GAP_W | Minimum inter-frame gap in bit ticks |
| crc_done | input | 1 | Check verdict for the finished frame is settled |
| crc_err | input | 1 | Check verdict: 1 means error |
| sdi | input | 1 | Serial return line |
| rd_en | input | 1 | Pop the oldest receive entry |
| frame_n | output | 1 | Active-low frame line |
| sdo | output | 1 | Serial outgoing data line |
| busy | output | 1 | A transfer is pending, running or awaiting its verdict |
| rd_word | output | FRAME_W | Oldest received word |
| rd_err | output | 1 | Error bit of the oldest received word |
| rx_not_empty | output | 1 | Receive queue holds at least one entry |
| overflow | output | 1 | Sticky: a received word was dropped |

## Verification
busy is due one cycle after an accepted start. frame_n and sdo change at the edge of the tick cycle itself, so the bench drives each tick for exactly one cycle and samples at the following falling edge. The sdi bit for index k is set just before tick k+1, and sdo is captured in the same window. rx_not_empty, busy and overflow follow a crc_done or rd_en pulse one cycle later, so they are checked at the falling edge after that pulse. The gap is checked by counting the tick cycles in which frame_n was high until it falls, and comparing the count with gap_ticks+1 of the previous frame.

// File: rtl/sfe_pkg.sv
package sfe_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ARMED = 2'd1,
    ST_SHIFT = 2'd2,
    ST_CRC   = 2'd3
  } sfe_state_t;

  // next value of a down-counter that reloads at frame end
  function automatic logic [15:0] gap_next(input logic [15:0] cnt, input logic tick,
                                           input logic reload, input logic [15:0] val);
    if (reload) return val;
    if (tick && cnt != 16'd0) return cnt - 16'd1;
    return cnt;
  endfunction
endpackage

// File: rtl/sfe_gap_timer.sv
module sfe_gap_timer #(
  parameter int GAP_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bit_tick,
  input  logic             reload,
  input  logic [GAP_W-1:0] reload_val,
  output logic             gap_done
);
  import sfe_pkg::*;

  logic [GAP_W-1:0] cnt;
  logic [15:0]      nxt;

  always_comb nxt = gap_next(16'(cnt), bit_tick, reload, 16'(reload_val));

  always_ff @(posedge clk) begin
    if (!rst_n) cnt <= '0;
    else        cnt <= nxt[GAP_W-1:0];
  end

  assign gap_done = (cnt == '0);

  // R3
  gap_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(bit_tick) && !$past(reload)) |-> $stable(cnt));
endmodule

// File: rtl/sfe_shifter.sv
module sfe_shifter #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         bit_tick,
  input  logic         launch,
  input  logic [W-1:0] load_word,
  input  logic         sdi,
  output logic         sdo,
  output logic         frame_n,
  output logic         last_tick,
  output logic [W-1:0] rx_word
);
  localparam int BCNT_W = (W > 1) ? $clog2(W) : 1;

  logic [W-1:0]      tx_sr;
  logic [W-1:0]      rx_sr;
  logic [BCNT_W-1:0] bcnt;
  logic              active;

  function automatic logic [W-1:0] shift_in(input logic [W-1:0] v, input logic b);
    return {v[W-2:0], b};
  endfunction

  assign last_tick = active && bit_tick && (bcnt == BCNT_W'(W-1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tx_sr  <= '0;
      rx_sr  <= '0;
      bcnt   <= '0;
      active <= 1'b0;
    end else if (launch) begin
      tx_sr  <= load_word;
      bcnt   <= '0;
      active <= 1'b1;
    end else if (active && bit_tick) begin
      rx_sr <= shift_in(rx_sr, sdi);
      tx_sr <= shift_in(tx_sr, 1'b0);
      bcnt  <= bcnt + 1'b1;
      if (last_tick) active <= 1'b0;
    end
  end

  assign sdo     = active ? tx_sr[W-1] : 1'b0;
  assign frame_n = !active;
  assign rx_word = rx_sr;

  // R4
  sdo_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(bit_tick) |-> $stable(sdo));
  // R6
  frame_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(frame_n) |-> $past(bit_tick));
endmodule

// File: rtl/sfe_rx_fifo.sv
module sfe_rx_fifo #(
  parameter int W     = 17,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr,
  input  logic [W-1:0] wr_data,
  input  logic         rd,
  output logic [W-1:0] rd_data,
  output logic         not_empty,
  output logic         overflow
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [W-1:0]     mem [DEPTH];
  logic [PTR_W-1:0] wptr, rptr;
  logic [CNT_W-1:0] count;
  logic             full, wr_ok, rd_ok;

  function automatic logic [PTR_W-1:0] ptr_next(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH-1)) ? '0 : p + 1'b1;
  endfunction

  assign full  = (count == CNT_W'(DEPTH));
  assign wr_ok = wr && !full;
  assign rd_ok = rd && (count != '0);

  always_ff @(posedge clk) begin
    if (wr_ok) mem[wptr] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wptr     <= '0;
      rptr     <= '0;
      count    <= '0;
      overflow <= 1'b0;
    end else begin
      if (wr_ok) wptr <= ptr_next(wptr);
      if (rd_ok) rptr <= ptr_next(rptr);
      if (wr_ok && !rd_ok)      count <= count + 1'b1;
      else if (rd_ok && !wr_ok) count <= count - 1'b1;
      if (wr && full) overflow <= 1'b1;
    end
  end

  assign rd_data   = mem[rptr];
  assign not_empty = (count != '0);

  // R9
  fifo_depth_chk: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CNT_W'(DEPTH));
  // R9
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    overflow |=> overflow);
  // R10
  empty_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!not_empty && !wr) |=> !not_empty);
endmodule

// File: rtl/sbus_frame_engine.sv
module sbus_frame_engine #(
  parameter int FRAME_W = 16,
  parameter int DEPTH   = 4,
  parameter int GAP_W   = 6
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bit_tick,
  input  logic               start,
  input  logic [FRAME_W-1:0] tx_word,
  input  logic [GAP_W-1:0]   gap_ticks,
  input  logic               crc_done,
  input  logic               crc_err,
  input  logic               sdi,
  input  logic               rd_en,
  output logic               frame_n,
  output logic               sdo,
  output logic               busy,
  output logic [FRAME_W-1:0] rd_word,
  output logic               rd_err,
  output logic               rx_not_empty,
  output logic               overflow
);
  import sfe_pkg::*;

  localparam int ENT_W = FRAME_W + 1;

  sfe_state_t         state;
  logic [FRAME_W-1:0] hold_word;
  logic               gap_done, launch, last_tick, store;
  logic [FRAME_W-1:0] rx_word;
  logic [ENT_W-1:0]   head;

  assign launch = (state == ST_ARMED) && bit_tick && gap_done;
  assign store  = (state == ST_CRC) && crc_done;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      hold_word <= '0;
    end else begin
      case (state)
        ST_IDLE:  if (start) begin
                    hold_word <= tx_word;
                    state     <= ST_ARMED;
                  end
        ST_ARMED: if (launch)    state <= ST_SHIFT;
        ST_SHIFT: if (last_tick) state <= ST_CRC;
        ST_CRC:   if (crc_done)  state <= ST_IDLE;
        default:                 state <= ST_IDLE;
      endcase
    end
  end

  assign busy = (state != ST_IDLE);

  sfe_gap_timer #(.GAP_W(GAP_W)) u_gap (
    .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick),
    .reload(last_tick), .reload_val(gap_ticks), .gap_done(gap_done)
  );

  sfe_shifter #(.W(FRAME_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .launch(launch),
    .load_word(hold_word), .sdi(sdi), .sdo(sdo), .frame_n(frame_n),
    .last_tick(last_tick), .rx_word(rx_word)
  );

  sfe_rx_fifo #(.W(ENT_W), .DEPTH(DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_n), .wr(store), .wr_data({crc_err, rx_word}),
    .rd(rd_en), .rd_data(head), .not_empty(rx_not_empty), .overflow(overflow)
  );

  assign rd_word = head[FRAME_W-1:0];
  assign rd_err  = head[FRAME_W];

  // R3
  gap_launch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(frame_n) |-> $past(gap_done && bit_tick));
  // R7
  settle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_not_empty) |-> $past(crc_done && state == ST_CRC));
  // R2
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(hold_word));
  // R11
  idle_crc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !rx_not_empty) |=> !rx_not_empty);
endmodule

// File: tb/sbus_frame_engine_test.sv
module sbus_frame_engine_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bit_tick = 1'b0, start = 1'b0, crc_done = 1'b0, crc_err = 1'b0;
  logic sdi = 1'b0, rd_en = 1'b0;
  logic [15:0] tx_word = '0;
  logic [5:0]  gap_ticks = '0;
  logic frame_n, sdo, busy, rd_err, rx_not_empty, overflow;
  logic [15:0] rd_word;

  int total = 0, bad = 0;
  logic [15:0] mq_w [4];
  logic        mq_e [4];
  int mcount = 0;
  logic exp_ovf = 1'b0;
  int exp_pre = 1;

  always #2 clk = ~clk;

  sbus_frame_engine uut (
    .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .start(start), .tx_word(tx_word),
    .gap_ticks(gap_ticks), .crc_done(crc_done), .crc_err(crc_err), .sdi(sdi),
    .rd_en(rd_en), .frame_n(frame_n), .sdo(sdo), .busy(busy), .rd_word(rd_word),
    .rd_err(rd_err), .rx_not_empty(rx_not_empty), .overflow(overflow)
  );

  task automatic chk(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int pre_expected(input logic [5:0] g);
    return int'(g) + 1;
  endfunction

  task automatic model_push(input logic [15:0] w, input logic e);
    if (mcount < 4) begin
      mq_w[mcount] = w; mq_e[mcount] = e; mcount++;
    end else exp_ovf = 1'b1;
  endtask

  task automatic run_frame(input logic [15:0] tx, input logic [15:0] rx,
                           input logic err, input logic [5:0] gap);
    int pre = 0, k = 0, guard = 0;
    logic [15:0] cap = '0;
    logic low, fin = 1'b0;
    gap_ticks = gap;
    start = 1'b1; tx_word = tx;
    @(negedge clk); start = 1'b0;
    chk(busy == 1'b1, "R2 busy after start", busy, 1);
    start = 1'b1; tx_word = ~tx;
    @(negedge clk); start = 1'b0; tx_word = tx;
    while (!fin && guard < 200) begin
      guard++;
      low = !frame_n;
      if (low) begin cap[15-k] = sdo; sdi = rx[15-k]; end
      bit_tick = 1'b1; @(negedge clk); bit_tick = 1'b0;
      if (!low) begin
        pre++;
        if (!frame_n) chk(pre == exp_pre, "R3 gap ticks", pre, exp_pre);
      end else begin
        k++;
        if (k < 16) begin
          if (frame_n) begin chk(1'b0, "R6 frame_n early rise", k, 16); fin = 1'b1; end
        end else begin
          chk(frame_n == 1'b1, "R6 frame_n high at last tick", frame_n, 1);
          fin = 1'b1;
        end
      end
      @(negedge clk);
    end
    chk(cap == tx, "R4 R2 sdo msb first", cap, tx);
    chk(sdo == 1'b0, "R4 sdo idle", sdo, 0);
    repeat (2) @(negedge clk);
    chk(rx_not_empty == (mcount > 0), "R7 no store before crc_done", rx_not_empty, mcount > 0);
    crc_done = 1'b1; crc_err = err;
    @(negedge clk); crc_done = 1'b0; crc_err = 1'b0;
    model_push(rx, err);
    chk(busy == 1'b0, "R7 busy clears", busy, 0);
    chk(rx_not_empty == 1'b1, "R7 not empty after store", rx_not_empty, 1);
    chk(overflow == exp_ovf, "R9 overflow flag", overflow, exp_ovf);
    exp_pre = pre_expected(gap);
  endtask

  task automatic pop_check();
    chk(rd_word == mq_w[0], "R5 R8 head word", rd_word, mq_w[0]);
    chk(rd_err == mq_e[0], "R8 head error bit", rd_err, mq_e[0]);
    rd_en = 1'b1; @(negedge clk); rd_en = 1'b0;
    for (int i = 0; i < 3; i++) begin mq_w[i] = mq_w[i+1]; mq_e[i] = mq_e[i+1]; end
    mcount--;
    chk(rx_not_empty == (mcount > 0), "R8 not empty after pop", rx_not_empty, mcount > 0);
  endtask

  initial begin
    #(4 * 190000);
    bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1
    chk(frame_n == 1'b1, "R1 frame_n reset", frame_n, 1);
    chk(sdo == 1'b0, "R1 sdo reset", sdo, 0);
    chk(busy == 1'b0, "R1 busy reset", busy, 0);
    chk(rx_not_empty == 1'b0, "R1 not empty reset", rx_not_empty, 0);
    chk(overflow == 1'b0, "R1 overflow reset", overflow, 0);

    // R11: stray verdict while idle
    crc_done = 1'b1; crc_err = 1'b1; @(negedge clk); crc_done = 1'b0; crc_err = 1'b0;
    @(negedge clk);
    chk(rx_not_empty == 1'b0, "R11 stray crc_done queued nothing", rx_not_empty, 0);
    chk(busy == 1'b0, "R11 stray crc_done busy", busy, 0);

    // R10: pop on empty
    rd_en = 1'b1; @(negedge clk); rd_en = 1'b0;
    chk(rx_not_empty == 1'b0, "R10 pop on empty", rx_not_empty, 0);

    run_frame(16'hA5C3, 16'h3C5A, 1'b0, 6'd0);
    pop_check();
    run_frame(16'h8001, 16'hFFFF, 1'b1, 6'd3);
    run_frame(16'h7FFE, 16'h0000, 1'b0, 6'd0);
    pop_check();
    pop_check();
    // R10: after the empty pop the pointers must still line up
    rd_en = 1'b1; @(negedge clk); rd_en = 1'b0;
    chk(rx_not_empty == 1'b0, "R10 second empty pop", rx_not_empty, 0);
    run_frame(16'h1234, 16'hBEEF, 1'b1, 6'd1);
    pop_check();

    for (int n = 0; n < 10; n++) begin
      run_frame(16'($urandom), 16'($urandom), 1'($urandom), 6'($urandom_range(0, 4)));
      if (mcount > 0 && ($urandom & 1) == 1) pop_check();
    end
    while (mcount > 0) pop_check();

    // R9: five stores with no pops
    for (int n = 0; n < 5; n++)
      run_frame(16'h0F00 + 16'(n), 16'hC000 + 16'(n), 1'(n), 6'd2);
    chk(overflow == 1'b1, "R9 overflow after fifth store", overflow, 1);
    while (mcount > 0) pop_check();
    chk(overflow == 1'b1, "R9 overflow sticky", overflow, 1);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule